// File: doc/BRIEF.md
# External SRAM Bus Controller

This block turns single read or write requests from an on-chip master into the strobe sequence of an asynchronous external memory bus. Each access has three phases. In the setup phase a chip select goes low together with the address. In the strobe phase the output enable (for a read) or a write strobe (for a write) is held low for a programmed number of wait states. In the closing phase all strobes are high again and the done pulse is returned to the requester. Slow devices can pull a hold input to lengthen the strobe phase beyond the programmed count.

The external data bus is either 8 or 16 bits wide, selected by a configuration input. On the narrow bus a 16-bit request is split into two byte accesses, most significant byte first at the lower address. The top address bits select one of four chip selects, and the remaining bits go out on the external address lines. The data bus is modelled as separate output, output-enable and input vectors, so that pad tristating stays outside the block.

Top module: `ext_sram_ctrl`

## Requirements
- R1: With the hold input low, an accepted single-beat request shows chip select low for W+1 cycles, the read or write strobe low for W cycles, and the done pulse in cycle W+2 counted from the accepting edge, where W is the effective wait count.
- R2: The effective wait count W equals `cfg_wait`, except that a programmed 0 gives W = 1 (same timing as 1).
- R3: In every beat the chip select falls exactly one cycle before output enable or write strobe falls.
- R4: Chip select, output enable and write strobes rise in the same cycle at the end of each beat.
- R5: `eb_hold` passes through a two-flop synchronizer and is examined only once the wait count has run out. While it stays high the strobe phase continues. After it falls, the strobes rise on the third clock edge. A hold pulse that is gone before the waits expire does not change the timing.
- R6: For writes `eb_doe` is high from the chip-select cycle through the cycle after the write strobe rises (W+2 cycles per beat). For reads and when idle it is low.
- R7: `req_ready` is high only while idle. A request raised while busy is ignored. `done` is high for exactly one cycle per request.
- R8: With `cfg_bus16`=0, a 16-bit request (`req_size16`=1, address bit 0 ignored) runs as two beats: `req_wdata[15:8]` / read byte to `rd_data[15:8]` at the even address, then bits [7:0] at the odd address. Data uses lane [7:0] and strobe `eb_we_n[0]` only. Done follows the second beat, in cycle 2(W+2).
- R9: With `cfg_bus16`=1, `eb_addr` is the byte address shifted right by one. A 16-bit request is one beat with both strobes low (`eb_we_n`=00) and the full word on the bus. A byte request uses lane [15:8] / `eb_we_n[1]` at an even address and lane [7:0] / `eb_we_n[0]` at an odd address. Byte reads return in `rd_data[7:0]` with the upper byte zero.
- R10: Address bits [ADDR_W-1:ADDR_W-2] select chip select `eb_cs_n[i]`. At most one chip select is ever low, and none is low while idle.
- R11: After reset, and whenever idle, all strobes are high, `eb_doe` is low and `req_ready` is high. Read data is captured on the last strobe-phase edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wait | input | WAIT_W | Programmed wait-state count |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | ADDR_W | Byte address; top bits select the chip select |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid from done onward |
| eb_addr | output | ADDR_W-2 | External address |
| eb_cs_n | output | CS_N | Chip selects, active low |
| eb_oe_n | output | 1 | Output enable, active low |
| eb_we_n | output | 2 | Write strobes per byte lane, active low |
| eb_dout | output | 16 | Write data to the pads |
| eb_doe | output | 1 | Pad driver enable for eb_dout |
| eb_din | input | 16 | Read data from the pads |
| eb_hold | input | 1 | Asynchronous stretch request from the device |

## Verification
A wrong phase or a wrong wait count shows at the pins within the same beat. The strobe run is too long or too short, or the chip-select lead differs from one cycle, so cycle counts of the strobes taken per beat expose it before done. A wrong beat index or lane choice shows up as a wrong address, strobe or data byte on the first mis-steered write, or as a wrong byte in rd_data at done. A stuck hold path shows up as a strobe phase that either ignores a held hold or fails to end three edges after release.

// File: rtl/sram_ctrl_pkg.sv
// Shared definitions for the external SRAM controller.
// Assumes: a single clock domain, data path fixed at 16 bits.
package sram_ctrl_pkg;
    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_CLOSE
    } phase_t;
endpackage

// File: rtl/sram_hold_sync.sv
// Synchronizer for the asynchronous hold input.
// Assumes: STAGES >= 2; hold is asynchronous to clk.
module sram_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_async,
    output logic hold_sync
);
    logic [STAGES-1:0] chain_q;

    // shift the raw hold level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], hold_async};
    end

    assign hold_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sram_wait_ctr.sv
// Wait-state down counter for the strobe phase.
// Loads max(cfg,1)-1 so the strobe lasts max(cfg,1) cycles.
// Assumes: load and dec are never asserted together.
module sram_wait_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] cfg,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    // load the remaining strobe cycles, or count them down
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (cfg == '0) ? '0 : cfg - CW'(1);
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_lane.sv
// Byte-lane steering: external address, write data, write strobe mask
// and read data merge for 8- and 16-bit bus widths.
// Assumes: big-endian byte order; 16-bit requests are word aligned.
module sram_lane
    import sram_ctrl_pkg::*;
#(
    parameter int EXT_AW = 18
) (
    input  logic              bus16,
    input  logic              size16,
    input  logic              beat,
    input  logic [EXT_AW-1:0] baddr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [BUS_W-1:0]  din,
    input  logic [BYTE_W-1:0] rd_hi,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [BUS_W-1:0]  dout,
    output logic [1:0]        we_mask,
    output logic [BUS_W-1:0]  rd_next
);
    logic [BYTE_W-1:0] wbyte;

    // select address, data lanes and strobes for the current beat
    always_comb begin
        wbyte = wdata[BYTE_W-1:0];
        if (bus16) begin
            ext_addr = {1'b0, baddr[EXT_AW-1:1]};
            if (size16) begin
                dout    = wdata;
                we_mask = 2'b11;
                rd_next = din;
            end else begin
                dout    = {wbyte, wbyte};
                we_mask = baddr[0] ? 2'b01 : 2'b10;
                rd_next = {{BYTE_W{1'b0}},
                           baddr[0] ? din[BYTE_W-1:0] : din[BUS_W-1:BYTE_W]};
            end
        end else begin
            if (size16) begin
                ext_addr = {baddr[EXT_AW-1:1], beat};
                wbyte    = beat ? wdata[BYTE_W-1:0] : wdata[BUS_W-1:BYTE_W];
                rd_next  = beat ? {rd_hi, din[BYTE_W-1:0]}
                                : {din[BYTE_W-1:0], {BYTE_W{1'b0}}};
            end else begin
                ext_addr = baddr;
                rd_next  = {{BYTE_W{1'b0}}, din[BYTE_W-1:0]};
            end
            dout    = {{BYTE_W{1'b0}}, wbyte};
            we_mask = 2'b01;
        end
    end
endmodule

// File: rtl/ext_sram_ctrl.sv
// External asynchronous SRAM bus controller (top).
// Runs setup / strobe / close phases per beat, counts wait states,
// honours the synchronized hold input and splits 16-bit requests on
// the 8-bit bus. Assumes all strobes active low, one request at a time.
module ext_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter  int ADDR_W = 20,
    parameter  int CS_N   = 4,
    parameter  int WAIT_W = 4,
    localparam int SEL_W  = $clog2(CS_N),
    localparam int EXT_AW = ADDR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_bus16,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_size16,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [BUS_W-1:0]  rd_data,
    output logic [EXT_AW-1:0] eb_addr,
    output logic [CS_N-1:0]   eb_cs_n,
    output logic              eb_oe_n,
    output logic [1:0]        eb_we_n,
    output logic [BUS_W-1:0]  eb_dout,
    output logic              eb_doe,
    input  logic [BUS_W-1:0]  eb_din,
    input  logic              eb_hold
);
    phase_t             phase_q;
    logic               beat_q;
    logic               wr_q, size16_q, bus16_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [BUS_W-1:0]   wdata_q, rd_q;
    logic               hold_s, waits_done, last_beat, accept, strobe_end;
    logic [SEL_W-1:0]   sel;
    logic [EXT_AW-1:0]  lane_addr;
    logic [BUS_W-1:0]   lane_dout, lane_rd;
    logic [1:0]         lane_we;
    logic               cs_phase, strobe_phase;

    sram_hold_sync #(.STAGES(2)) u_hold (
        .clk(clk), .rst_n(rst_n), .hold_async(eb_hold), .hold_sync(hold_s)
    );

    sram_wait_ctr #(.CW(WAIT_W)) u_wait (
        .clk(clk), .rst_n(rst_n),
        .load(phase_q == PH_SETUP), .dec(phase_q == PH_STROBE),
        .cfg(cfg_wait), .expired(waits_done)
    );

    sram_lane #(.EXT_AW(EXT_AW)) u_lane (
        .bus16(bus16_q), .size16(size16_q), .beat(beat_q),
        .baddr(addr_q[EXT_AW-1:0]), .wdata(wdata_q), .din(eb_din),
        .rd_hi(rd_q[BUS_W-1:BYTE_W]),
        .ext_addr(lane_addr), .dout(lane_dout), .we_mask(lane_we),
        .rd_next(lane_rd)
    );

    assign accept     = (phase_q == PH_IDLE) && req_valid;
    assign last_beat  = bus16_q || !size16_q || beat_q;
    assign strobe_end = (phase_q == PH_STROBE) && waits_done && !hold_s;
    assign sel        = addr_q[ADDR_W-1 -: SEL_W];

    // phase sequencing and beat tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            beat_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE:   if (accept) begin
                               phase_q <= PH_SETUP;
                               beat_q  <= 1'b0;
                           end
                PH_SETUP:  phase_q <= PH_STROBE;
                PH_STROBE: if (strobe_end) phase_q <= PH_CLOSE;
                PH_CLOSE:  if (last_beat) phase_q <= PH_IDLE;
                           else begin
                               phase_q <= PH_SETUP;
                               beat_q  <= 1'b1;
                           end
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // capture the request fields when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= 1'b0;
            size16_q <= 1'b0;
            bus16_q  <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            wr_q     <= req_write;
            size16_q <= req_size16;
            bus16_q  <= cfg_bus16;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    // sample read data on the last edge of the strobe phase
    always_ff @(posedge clk) begin
        if (!rst_n)                rd_q <= '0;
        else if (strobe_end && !wr_q) rd_q <= lane_rd;
    end

    assign cs_phase     = (phase_q == PH_SETUP) || (phase_q == PH_STROBE);
    assign strobe_phase = (phase_q == PH_STROBE);

    // one chip select per decoded address slot
    for (genvar g = 0; g < CS_N; g++) begin : g_cs
        assign eb_cs_n[g] = !(cs_phase && (sel == SEL_W'(g)));
    end

    assign eb_oe_n   = !(strobe_phase && !wr_q);
    assign eb_we_n   = ~(lane_we & {2{strobe_phase && wr_q}});
    assign eb_doe    = wr_q && (phase_q != PH_IDLE);
    assign eb_dout   = eb_doe ? lane_dout : '0;
    assign eb_addr   = lane_addr;
    assign req_ready = (phase_q == PH_IDLE);
    assign done      = (phase_q == PH_CLOSE) && last_beat;
    assign rd_data   = rd_q;
endmodule

// File: rtl/ext_sram_ctrl_chk.sv
// Protocol checker for ext_sram_ctrl, attached with bind.
// Assumes: observes only ports of the controller.
module ext_sram_ctrl_chk #(
    parameter int CS_N = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [CS_N-1:0] eb_cs_n,
    input logic            eb_oe_n,
    input logic [1:0]      eb_we_n,
    input logic            eb_doe,
    input logic            done,
    input logic            req_ready
);
    // R3
    oe_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eb_oe_n) |-> ($past(eb_cs_n) != '1));
    // R3
    we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(&eb_we_n) |-> ($past(eb_cs_n) != '1));
    // R4
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eb_oe_n) |-> (eb_cs_n == '1));
    // R4
    we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&eb_we_n) |-> (eb_cs_n == '1));
    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&eb_we_n) |-> eb_doe);
    // R6
    rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eb_oe_n |-> !eb_doe);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~eb_cs_n));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (eb_cs_n == '1 && eb_oe_n && (&eb_we_n) && !eb_doe));
endmodule

bind ext_sram_ctrl ext_sram_ctrl_chk #(.CS_N(CS_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .eb_cs_n(eb_cs_n), .eb_oe_n(eb_oe_n),
    .eb_we_n(eb_we_n), .eb_doe(eb_doe), .done(done), .req_ready(req_ready)
);

// File: tb/tb_ext_sram_ctrl.sv
// Directed bench for ext_sram_ctrl: one task per scenario.
module tb_ext_sram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_wait = 4'd1;
    logic        cfg_bus16 = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_size16 = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rd_data, eb_dout, eb_din;
    logic [17:0] eb_addr;
    logic [3:0]  eb_cs_n;
    logic        eb_oe_n, eb_doe;
    logic [1:0]  eb_we_n;
    logic        eb_hold = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    ext_sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_bus16(cfg_bus16),
        .req_valid(req_valid), .req_write(req_write), .req_size16(req_size16),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .eb_addr(eb_addr), .eb_cs_n(eb_cs_n),
        .eb_oe_n(eb_oe_n), .eb_we_n(eb_we_n), .eb_dout(eb_dout),
        .eb_doe(eb_doe), .eb_din(eb_din), .eb_hold(eb_hold)
    );

    function automatic logic [7:0] pat8(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    // memory model: data is a fixed function of the address
    assign eb_din = cfg_bus16 ? {pat8({eb_addr[6:0], 1'b0}), pat8({eb_addr[6:0], 1'b1})}
                              : {8'h00, pat8(eb_addr[7:0])};

    // bus monitor, sampled on the falling edge
    int cs_cyc, stb_cyc, doe_cyc, done_cyc, cs_falls, lead_err, rel_err, nwr;
    logic [3:0]  cs_seen;
    logic [17:0] wl_addr [4];
    logic [15:0] wl_data [4];
    logic [1:0]  wl_we   [4];
    logic        prev_cs_idle = 1'b1, prev_stb = 1'b0;
    int          fall_at = 0;

    always @(negedge clk) begin
        logic stb;
        stb = !eb_oe_n || !(&eb_we_n);
        if (eb_cs_n != 4'hF) begin cs_cyc++; cs_seen |= ~eb_cs_n; end
        if (stb) stb_cyc++;
        if (eb_doe) doe_cyc++;
        if (done) done_cyc++;
        if (eb_cs_n != 4'hF && prev_cs_idle) begin cs_falls++; fall_at = cyc; end
        if (stb && !prev_stb) begin
            if (cyc - fall_at != 1) lead_err++;
            if (!(&eb_we_n) && nwr < 4) begin
                wl_addr[nwr] = eb_addr; wl_data[nwr] = eb_dout; wl_we[nwr] = eb_we_n;
                nwr++;
            end
        end
        if (!stb && prev_stb && eb_cs_n != 4'hF) rel_err++;
        if (eb_cs_n == 4'hF && !prev_cs_idle && stb) rel_err++;
        prev_cs_idle = (eb_cs_n == 4'hF);
        prev_stb = stb;
        cyc++;
    end

    task automatic clear_mon();
        @(posedge clk);
        cs_cyc = 0; stb_cyc = 0; doe_cyc = 0; done_cyc = 0; cs_falls = 0;
        lead_err = 0; rel_err = 0; nwr = 0; cs_seen = '0;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // issue one request and return cycles from accept to done
    task automatic run(input bit w, input bit s16, input logic [19:0] a,
                       input logic [15:0] d, output int lat);
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size16 = s16; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        forever begin
            lat++;
            if (done || lat > 300) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
        chk(eb_cs_n == 4'hF && eb_oe_n && eb_we_n == 2'b11, "R11 strobes",
            int'({eb_cs_n, eb_oe_n, eb_we_n}), 'h7F);
        chk(!eb_doe && !done, "R11 doe/done", int'({eb_doe, done}), 0);
    endtask

    task automatic t_byte_read();
        int lat;
        cfg_bus16 = 1'b0; cfg_wait = 4'd3;
        run(1'b0, 1'b0, 20'h40123, 16'h0, lat);
        chk(lat == 5, "R1 latency", lat, 5);
        chk(stb_cyc == 3, "R1 strobe", stb_cyc, 3);
        chk(cs_cyc == 4, "R1 cs", cs_cyc, 4);
        chk(lead_err == 0, "R3 lead", lead_err, 0);
        chk(rel_err == 0, "R4 release", rel_err, 0);
        chk(cs_seen == 4'b0010, "R10 decode", int'(cs_seen), 2);
        chk(rd_data == {8'h00, pat8(8'h23)}, "R11 read data", int'(rd_data), int'(pat8(8'h23)));
        chk(doe_cyc == 0, "R6 read float", doe_cyc, 0);
    endtask

    task automatic t_zero_wait();
        int lat0, lat1, s0;
        cfg_bus16 = 1'b0;
        cfg_wait = 4'd0;
        run(1'b0, 1'b0, 20'h00010, 16'h0, lat0);
        s0 = stb_cyc;
        cfg_wait = 4'd1;
        run(1'b0, 1'b0, 20'h00010, 16'h0, lat1);
        chk(lat0 == 3 && lat1 == 3, "R2 zero as one", lat0, 3);
        chk(s0 == 1 && stb_cyc == 1, "R2 strobe", s0, 1);
    endtask

    task automatic t_long_write();
        int lat;
        cfg_bus16 = 1'b0; cfg_wait = 4'd15;
        run(1'b1, 1'b0, 20'hC0077, 16'h00A6, lat);
        chk(lat == 17, "R1 latency w15", lat, 17);
        chk(stb_cyc == 15, "R1 strobe w15", stb_cyc, 15);
        chk(doe_cyc == 17, "R6 drive window", doe_cyc, 17);
        chk(nwr == 1 && wl_addr[0] == 18'h00077 && wl_data[0] == 16'h00A6 && wl_we[0] == 2'b10,
            "R8 byte write", int'(wl_data[0]), 'hA6);
        chk(cs_seen == 4'b1000, "R10 decode hi", int'(cs_seen), 8);
        chk(eb_doe == 1'b0, "R6 idle float", int'(eb_doe), 0);
    endtask

    task automatic t_busy_ignored();
        cfg_bus16 = 1'b0; cfg_wait = 4'd4;
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_size16 = 1'b0;
        req_addr = 20'h00055; req_wdata = 16'h0011;
        @(negedge clk);
        req_addr = 20'h00066; req_wdata = 16'h0022;
        chk(req_ready == 1'b0, "R7 busy not ready", int'(req_ready), 0);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(cs_falls == 1 && nwr == 1, "R7 one access", cs_falls, 1);
        chk(wl_addr[0] == 18'h00055 && wl_data[0] == 16'h0011, "R7 first kept",
            int'(wl_addr[0]), 'h55);
        chk(done_cyc == 1, "R7 done width", done_cyc, 1);
        chk(req_ready == 1'b1, "R7 ready again", int'(req_ready), 1);
    endtask

    task automatic t_split_8bit();
        int lat;
        cfg_bus16 = 1'b0; cfg_wait = 4'd2;
        run(1'b1, 1'b1, 20'h40201, 16'hBEEF, lat);
        chk(lat == 8, "R8 two beats", lat, 8);
        chk(cs_falls == 2 && lead_err == 0 && rel_err == 0, "R8 beat shape", cs_falls, 2);
        chk(wl_addr[0] == 18'h00200 && wl_data[0] == 16'h00BE && wl_we[0] == 2'b10,
            "R8 first byte high", int'(wl_data[0]), 'hBE);
        chk(wl_addr[1] == 18'h00201 && wl_data[1] == 16'h00EF && wl_we[1] == 2'b10,
            "R8 second byte low", int'(wl_data[1]), 'hEF);
        chk(doe_cyc == 8, "R6 drive two beats", doe_cyc, 8);
        run(1'b0, 1'b0 | 1'b1, 20'h00124, 16'h0, lat);
        chk(rd_data == {pat8(8'h24), pat8(8'h25)}, "R8 read order",
            int'(rd_data), int'({pat8(8'h24), pat8(8'h25)}));
    endtask

    task automatic t_wide_bus();
        int lat;
        cfg_bus16 = 1'b1; cfg_wait = 4'd1;
        run(1'b1, 1'b1, 20'h80246, 16'h1234, lat);
        chk(lat == 3 && cs_falls == 1, "R9 one beat", lat, 3);
        chk(wl_addr[0] == 18'h00123 && wl_data[0] == 16'h1234 && wl_we[0] == 2'b00,
            "R9 word write", int'(wl_we[0]), 0);
        run(1'b1, 1'b0, 20'h00246, 16'h0077, lat);
        chk(wl_we[0] == 2'b01 && wl_data[0][15:8] == 8'h77, "R9 even lane", int'(wl_we[0]), 1);
        run(1'b1, 1'b0, 20'h00247, 16'h0088, lat);
        chk(wl_we[0] == 2'b10 && wl_data[0][7:0] == 8'h88, "R9 odd lane", int'(wl_we[0]), 2);
        run(1'b0, 1'b1, 20'h80246, 16'h0, lat);
        chk(rd_data == {pat8(8'h46), pat8(8'h47)}, "R9 word read",
            int'(rd_data), int'({pat8(8'h46), pat8(8'h47)}));
        run(1'b0, 1'b0, 20'h80246, 16'h0, lat);
        chk(rd_data == {8'h00, pat8(8'h46)}, "R9 even byte read", int'(rd_data), int'(pat8(8'h46)));
        run(1'b0, 1'b0, 20'h80247, 16'h0, lat);
        chk(rd_data == {8'h00, pat8(8'h47)}, "R9 odd byte read", int'(rd_data), int'(pat8(8'h47)));
        cfg_bus16 = 1'b0;
    endtask

    task automatic t_hold();
        int k;
        cfg_bus16 = 1'b0; cfg_wait = 4'd8;
        // short pulse inside the wait window: no effect
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size16 = 1'b0; req_addr = 20'h00033;
        eb_hold = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        eb_hold = 1'b0;
        repeat (12) @(negedge clk);
        chk(stb_cyc == 8, "R5 pulse ignored", stb_cyc, 8);
        // held hold stretches the strobe
        cfg_wait = 4'd2;
        eb_hold = 1'b1;
        repeat (3) @(negedge clk);
        clear_mon();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 20'h00034;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        chk(eb_oe_n == 1'b0 && done_cyc == 0, "R5 stretched", int'(eb_oe_n), 0);
        eb_hold = 1'b0;
        k = 0;
        do begin @(negedge clk); k++; end while (!done && k < 20);
        chk(k == 3, "R5 release delay", k, 3);
        chk(lead_err == 0 && rel_err == 0, "R5 shape", rel_err, 0);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_read();
        t_zero_wait();
        t_long_write();
        t_busy_ignored();
        t_split_8bit();
        t_wide_bus();
        t_hold();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule